// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Shifter

This block sends a fixed 32-bit answer-to-reset word onto a serial data line when a host asks for it. The host asks by holding a reset pin high across one full pulse of its serial clock and then lowering the reset pin. The first bit appears as soon as the reset pin falls. Each later falling edge of the serial clock presents the next bit, and after the last bit the block goes back to idle and releases the line.

A second request that arrives part-way through the stream starts the word again from its first bit. A reset pulse that does not enclose a clock pulse cancels the stream. A pending nonvolatile write cycle blocks any start. The host's serial clock and reset pin are sampled by a faster system clock, so they must each stay stable for at least two system clock cycles.

Top module: `atr_shifter`

## Requirements
- R1: While the system reset is asserted, and after it is released with no request, the output enable, the active flag and the data bit are all 0.
- R2: A rising then falling edge of the serial clock while the reset pin is high, followed by the reset pin going low with the busy input low, sets the active flag and the output enable and presents bit 0 of the word.
- R3: The word is the bytes 0x19, 0x20, 0xAA, 0x55 sent byte 0 first and least significant bit first within each byte, so that stream bit k is bit k mod 8 of byte k div 8. Each falling edge of the serial clock while active and with the reset pin low presents the next bit, and no other event advances it.
- R4: If the busy input is high when the reset pin falls, the block stays idle even though a clock pulse was seen.
- R5: A reset pin pulse from idle that encloses no clock pulse has no effect.
- R6: The falling serial clock edge that follows bit 31 returns the block to idle with the output enable low.
- R7: A reset pin pulse enclosing a clock pulse in the middle of a stream restarts the output at bit 0 when the reset pin falls, and the stream then continues with bit 1.
- R8: A reset pin pulse in the middle of a stream that encloses no clock pulse ends the stream and returns the block to idle.
- R9: Serial clock pulses while idle with the reset pin low have no effect, including after a request that the busy input refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous system reset |
| atr_req_i | input | 1 | Reset pin from the host; high requests an answer |
| ser_clk_i | input | 1 | Serial clock from the host |
| nv_busy_i | input | 1 | High while a nonvolatile write cycle runs |
| ser_do_o | output | 1 | Serial data bit, 0 when idle |
| ser_oe_o | output | 1 | Output enable for the data line driver |
| atr_active_o | output | 1 | High while the word is being sent |

## Verification
The case that is hardest to reach is a second request in the middle of a stream, because a restart and a plain continuation can show the same bit. The stimulus stops the stream at bit 3, a 1, and pulses the clock under the reset pin. After the pin falls, the output must show bit 0 and then bit 1, a 0, where a continued stream would have shown bit 4, a 1. An abort is driven from the same point in the stream, but with the clock left quiet under the reset pin.

// File: rtl/atr_shifter.sv
module atr_shifter #(
  parameter int                BITS     = 32,
  parameter logic [BITS-1:0]   ATR_WORD = 32'h55AA_2019
) (
  input  logic clk,
  input  logic rst_n,
  input  logic atr_req_i,
  input  logic ser_clk_i,
  input  logic nv_busy_i,
  output logic ser_do_o,
  output logic ser_oe_o,
  output logic atr_active_o
);

  localparam int            IW   = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [IW-1:0] LAST = IW'(BITS - 1);

  logic          sck_q, req_q, seen, active;
  logic [IW-1:0] idx;

  wire sck_rise = ser_clk_i & ~sck_q;
  wire sck_fall = ~ser_clk_i & sck_q;
  wire req_fall = ~atr_req_i & req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      req_q  <= 1'b0;
      seen   <= 1'b0;
      active <= 1'b0;
      idx    <= '0;
    end else begin
      sck_q <= ser_clk_i;
      req_q <= atr_req_i;
      if (atr_req_i && sck_rise) seen <= 1'b1;
      else if (!atr_req_i)       seen <= 1'b0;
      if (req_fall) begin
        active <= seen & ~nv_busy_i;
        idx    <= '0;
      end else if (active && !atr_req_i && sck_fall) begin
        if (idx == LAST) begin
          active <= 1'b0;
          idx    <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign atr_active_o = active;
  assign ser_oe_o     = active;
  assign ser_do_o     = active & ATR_WORD[idx];

  p_start_needs_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(req_q) && !$past(atr_req_i));

  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !$past(nv_busy_i));

  p_step_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && idx != $past(idx) && idx != '0)
      |-> $past(sck_q) && !$past(ser_clk_i) && !$past(atr_req_i));

  p_end_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && idx == LAST && sck_fall && !atr_req_i) |=> !atr_active_o);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && req_fall && !seen) |=> !atr_active_o);

endmodule

// File: tb/test_atr_shifter.sv
`timescale 1ns/1ps
module test_atr_shifter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, sck = 1'b0, busy = 1'b0;
  logic sdo, soe, act;
  int   applied = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  atr_shifter i_atr_shifter (
    .clk(clk), .rst_n(rst_n), .atr_req_i(req), .ser_clk_i(sck),
    .nv_busy_i(busy), .ser_do_o(sdo), .ser_oe_o(soe), .atr_active_o(act)
  );

  // entry = {req_tag[3:0], op[2:0], expected oe, expected data}
  // op: 0 req high, 1 req low, 2 clock pulse, 3 busy high, 4 busy low
  localparam logic [8:0] VEC [28] = '{
    {4'd9, 3'd2, 2'b00},  // R9 clock while idle
    {4'd5, 3'd0, 2'b00},
    {4'd5, 3'd1, 2'b00},  // R5 pulse without clock
    {4'd2, 3'd0, 2'b00},
    {4'd2, 3'd2, 2'b00},
    {4'd2, 3'd1, 2'b11},  // R2 bit 0 = 1
    {4'd3, 3'd2, 2'b10},  // R3 bit 1 = 0
    {4'd3, 3'd2, 2'b10},
    {4'd3, 3'd2, 2'b11},
    {4'd3, 3'd2, 2'b11},  // bit 4 = 1
    {4'd3, 3'd0, 2'b11},
    {4'd8, 3'd1, 2'b00},  // R8 abort
    {4'd4, 3'd3, 2'b00},
    {4'd4, 3'd0, 2'b00},
    {4'd4, 3'd2, 2'b00},
    {4'd4, 3'd1, 2'b00},  // R4 refused
    {4'd4, 3'd4, 2'b00},
    {4'd9, 3'd2, 2'b00},  // R9 no late start
    {4'd2, 3'd0, 2'b00},
    {4'd2, 3'd2, 2'b00},
    {4'd2, 3'd1, 2'b11},
    {4'd3, 3'd2, 2'b10},
    {4'd3, 3'd2, 2'b10},
    {4'd3, 3'd2, 2'b11},  // bit 3 = 1
    {4'd7, 3'd0, 2'b11},
    {4'd7, 3'd2, 2'b11},  // R7 no advance under request
    {4'd7, 3'd1, 2'b11},  // R7 restart at bit 0
    {4'd7, 3'd2, 2'b10}   // R7 bit 1, not bit 4
  };

  localparam logic [7:0] BYTES [4] = '{8'h19, 8'h20, 8'hAA, 8'h55};

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_op(input logic [2:0] op);
    @(negedge clk);
    case (op)
      3'd0: req = 1'b1;
      3'd1: req = 1'b0;
      3'd2: begin sck = 1'b1; settle(); sck = 1'b0; end
      3'd3: busy = 1'b1;
      default: busy = 1'b0;
    endcase
    settle();
  endtask

  task automatic chk(input int tag, input logic [1:0] actual, input logic [1:0] expected);
    applied++;
    if (actual !== expected) begin
      miscompares++;
      $display("FAIL R%0d: {oe,do} actual %b expected %b", tag, actual, expected);
    end
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(1, {soe, sdo}, 2'b00);           // R1 during reset
    rst_n = 1'b1;
    settle();
    chk(1, {act, sdo}, 2'b00);           // R1 after release

    for (int i = 0; i < 28; i++) begin
      do_op(VEC[i][4:2]);
      chk(int'(VEC[i][8:5]), {soe, sdo}, VEC[i][1:0]);
    end

    // R1: system reset in mid-stream clears everything
    @(negedge clk); rst_n = 1'b0;
    settle();
    chk(1, {act, soe}, 2'b00);
    rst_n = 1'b1;
    settle();

    // R3 full word and R6 return to idle
    do_op(3'd0); do_op(3'd2); do_op(3'd1);
    for (int k = 0; k < 32; k++) begin
      chk(3, {soe, sdo}, {1'b1, BYTES[k / 8][k % 8]});
      do_op(3'd2);
    end
    chk(6, {soe, act}, 2'b00);
    do_op(3'd2);
    chk(6, {soe, sdo}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule